// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block is the transmit half of a descriptor-ring DMA engine. Software builds a ring of four-word descriptors in host memory. It hands each descriptor to the engine by setting the ownership bit of its status word, loads the address of the first descriptor, and pulses a start input. The engine then walks the ring through a single-word memory master port. For every owned descriptor it fetches the control word, the buffer pointer and the link word. It reads the buffer a word at a time and pushes the bytes into a small byte FIFO, tagged with start-of-frame and end-of-frame markers. It then writes the status word back with ownership cleared and moves on. The first descriptor it finds still held by software ends the walk, and the engine waits for the next start pulse.

The byte stream leaves through a valid/ready transmit interface toward a MAC. In store-and-forward mode a byte is offered only once the end-of-frame byte of the oldest frame has entered the FIFO. In cut-through mode bytes are offered as soon as they arrive. A pointer output always shows the address of the descriptor being worked on, or the one the engine stopped at. Frames sent in store-and-forward mode must fit in the FIFO. Load and start pulses that arrive while a walk is running are not acted on.

Top module: `tdma_tx_reader`

## Requirements
- R1: After reset the block is idle: `busy`=0, `mem_req`=0, `tx_valid`=0 and `cur_desc`=0.
- R2: While idle, `base_wr` loads `base_addr` into `cur_desc`. A `kick` pulse while idle starts a walk whose first memory access is a read of the status word at `cur_desc`. A later `kick` with no new `base_wr` resumes from the descriptor where the last walk stopped.
- R3: Descriptor layout, as byte offsets from the descriptor address: +0 status (bit 31 = owned by engine), +4 control, +8 buffer address, +12 link address. Control bits: [LEN_W-1:0] byte length, 24 = chained, 29 = first of frame, 30 = last of frame. For an owned descriptor the engine reads +0, +4, +8 and +12 in that order.
- R4: A status word with bit 31 clear ends the walk. The engine makes no further memory access, `busy` falls, and `cur_desc` keeps that descriptor's address.
- R5: Exactly `length` bytes are sent from a word-aligned buffer. The buffer is read at buffer+0, +4, +8 and so on, and each word is sent byte 0 (bits 7:0) first.
- R6: `tx_first` is 1 only on the first byte of a descriptor whose bit 29 is set. `tx_last` is 1 only on the final byte of a descriptor whose bit 30 is set.
- R7: After its last buffer read, each owned descriptor is written back at +0. The written value is the status word read earlier with bit 31 cleared and every other bit kept.
- R8: After the write-back the engine moves to the link word when bit 24 is set, and to descriptor address +16 when it is clear. `cur_desc` follows.
- R9: A descriptor of length 0 sends no byte and reads no buffer word, but it is still written back and followed.
- R10: With `sf_mode`=1, `tx_valid` stays 0 until the last buffer word of the frame has been read. With `sf_mode`=0, bytes are offered before that read.
- R11: A memory request keeps `mem_addr`, `mem_we` and `mem_wdata` unchanged until `mem_ack`. Only one access is outstanding at a time.
- R12: While `tx_valid`=1 and `tx_ready`=0, the offered byte and markers stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kick | input | 1 | Start pulse for a ring walk |
| base_wr | input | 1 | Load strobe for the descriptor pointer |
| base_addr | input | ADDR_W | Descriptor pointer value to load |
| sf_mode | input | 1 | 1 = store-and-forward, 0 = cut-through |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| tx_valid | output | 1 | Byte offered to the MAC |
| tx_ready | input | 1 | MAC accepts the byte |
| tx_data | output | 8 | Byte value |
| tx_first | output | 1 | Start-of-frame marker |
| tx_last | output | 1 | End-of-frame marker |
| busy | output | 1 | A walk is in progress |
| cur_desc | output | ADDR_W | Address of current descriptor |

## Verification
The bench builds the block with its defaults: 32-bit addresses, an 11-bit length field and a 16-entry byte FIFO. Sixteen entries is enough to hold a whole 13-byte frame in store-and-forward mode. It is also small enough that the four-free-slot rule for buffer reads throttles the walker when the transmit side stalls. The memory model answers after zero to two wait cycles, which exercises request hold. The reference walk, computed from a copy of memory, predicts every access and every byte across chained, sequential, zero-length, wrap-around and resumed walks.

// File: rtl/tdma_pkg.sv
`timescale 1ns/1ps
package tdma_pkg;
  localparam int OWN_BIT    = 31;
  localparam int LAST_BIT   = 30;
  localparam int FIRST_BIT  = 29;
  localparam int CHAIN_BIT  = 24;
  localparam int DESC_BYTES = 16;
  localparam logic [31:0] OWN_MASK = 32'h8000_0000;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STAT, ST_CTL, ST_BUF, ST_LINK, ST_DATA, ST_PUSH, ST_WBACK
  } walk_st_e;

  typedef struct packed {
    logic       last;
    logic       first;
    logic [7:0] data;
  } tx_beat_t;
endpackage

// File: rtl/tdma_byte_fifo.sv
`timescale 1ns/1ps
module tdma_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [W-1:0]                 wr_data,
  input  logic                         rd_en,
  output logic [W-1:0]                 rd_data,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   free
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    if (wr_en) wp_d = wp_q + PW'(1);
    if (rd_en) rp_d = rp_q + PW'(1);
    cnt_d = cnt_q + CW'(wr_en) - CW'(rd_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) slot_q[wp_q] <= wr_data;
  end

  assign rd_data = slot_q[rp_q];
  assign empty   = (cnt_q == '0);
  assign free    = CW'(DEPTH) - cnt_q;

  // The walker only pushes after checking headroom; a push into a full FIFO would lose bytes
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (cnt_q < CW'(DEPTH)));
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (cnt_q != '0));
endmodule

// File: rtl/tdma_sf_gate.sv
`timescale 1ns/1ps
module tdma_sf_gate #(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sf_mode,
  input  logic push,
  input  logic push_last,
  input  logic pop,
  input  logic pop_last,
  input  logic empty,
  output logic avail
);
  localparam int CW = $clog2(DEPTH+1);

  logic [CW-1:0] frames_q, frames_d;

  always_comb begin
    frames_d = frames_q + CW'(push && push_last) - CW'(pop && pop_last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frames_q <= '0;
    else        frames_q <= frames_d;
  end

  assign avail = !empty && (!sf_mode || (frames_q != '0));

  // An end-of-frame byte leaving the FIFO must have been counted on entry
  assert_frame_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && pop_last) |-> (frames_q != '0));
endmodule

// File: rtl/tdma_walker.sv
`timescale 1ns/1ps
module tdma_walker
  import tdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 11,
  parameter int FREE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic [FREE_W-1:0] fifo_free,
  output logic              push,
  output tx_beat_t          push_beat,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_desc
);
  localparam logic [ADDR_W-1:0] OFS_CTL  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_BUF  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFS_LINK = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] STRIDE   = ADDR_W'(DESC_BYTES);
  localparam logic [ADDR_W-1:0] WORD     = ADDR_W'(4);

  walk_st_e          st_q, st_d;
  logic [ADDR_W-1:0] cur_q, cur_d, buf_q, buf_d, link_q, link_d;
  logic [31:0]       stat_q, stat_d, word_q, word_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [1:0]        lane_q, lane_d;
  logic              lead_q, lead_d, ffirst_q, ffirst_d, flast_q, flast_d;
  logic              chain_q, chain_d;

  always_comb begin
    st_d     = st_q;
    cur_d    = cur_q;
    buf_d    = buf_q;
    link_d   = link_q;
    stat_d   = stat_q;
    word_d   = word_q;
    rem_d    = rem_q;
    lane_d   = lane_q;
    lead_d   = lead_q;
    ffirst_d = ffirst_q;
    flast_d  = flast_q;
    chain_d  = chain_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_q;
    mem_wdata = '0;
    push      = 1'b0;
    push_beat = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (base_wr) cur_d = base_addr;
        if (kick)    st_d  = ST_STAT;
      end
      ST_STAT: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          stat_d = mem_rdata;
          st_d   = mem_rdata[OWN_BIT] ? ST_CTL : ST_IDLE;
        end
      end
      ST_CTL: begin
        mem_req  = 1'b1;
        mem_addr = cur_q + OFS_CTL;
        if (mem_ack) begin
          rem_d    = mem_rdata[LEN_W-1:0];
          ffirst_d = mem_rdata[FIRST_BIT];
          flast_d  = mem_rdata[LAST_BIT];
          chain_d  = mem_rdata[CHAIN_BIT];
          st_d     = ST_BUF;
        end
      end
      ST_BUF: begin
        mem_req  = 1'b1;
        mem_addr = cur_q + OFS_BUF;
        if (mem_ack) begin
          buf_d = mem_rdata[ADDR_W-1:0];
          st_d  = ST_LINK;
        end
      end
      ST_LINK: begin
        mem_req  = 1'b1;
        mem_addr = cur_q + OFS_LINK;
        if (mem_ack) begin
          link_d = mem_rdata[ADDR_W-1:0];
          lead_d = 1'b1;
          st_d   = (rem_q == '0) ? ST_WBACK : ST_DATA;
        end
      end
      ST_DATA: begin
        mem_addr = buf_q;
        if (fifo_free >= FREE_W'(4)) begin
          mem_req = 1'b1;
          if (mem_ack) begin
            word_d = mem_rdata;
            lane_d = 2'd0;
            buf_d  = buf_q + WORD;
            st_d   = ST_PUSH;
          end
        end
      end
      ST_PUSH: begin
        push            = 1'b1;
        push_beat.data  = word_q[8*lane_q +: 8];
        push_beat.first = ffirst_q && lead_q;
        push_beat.last  = flast_q && (rem_q == LEN_W'(1));
        rem_d  = rem_q - LEN_W'(1);
        lead_d = 1'b0;
        lane_d = lane_q + 2'd1;
        if (rem_q == LEN_W'(1))  st_d = ST_WBACK;
        else if (lane_q == 2'd3) st_d = ST_DATA;
      end
      ST_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = stat_q & ~OWN_MASK;
        if (mem_ack) begin
          cur_d = chain_q ? link_q : (cur_q + STRIDE);
          st_d  = ST_STAT;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cur_q    <= '0;
      buf_q    <= '0;
      link_q   <= '0;
      stat_q   <= '0;
      word_q   <= '0;
      rem_q    <= '0;
      lane_q   <= '0;
      lead_q   <= 1'b0;
      ffirst_q <= 1'b0;
      flast_q  <= 1'b0;
      chain_q  <= 1'b0;
    end else begin
      st_q     <= st_d;
      cur_q    <= cur_d;
      buf_q    <= buf_d;
      link_q   <= link_d;
      stat_q   <= stat_d;
      word_q   <= word_d;
      rem_q    <= rem_d;
      lane_q   <= lane_d;
      lead_q   <= lead_d;
      ffirst_q <= ffirst_d;
      flast_q  <= flast_d;
      chain_q  <= chain_d;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign cur_desc = cur_q;

  assert_hold_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_stop_unowned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STAT && mem_ack && !mem_rdata[OWN_BIT]) |=> (!busy && !mem_req && $stable(cur_desc)));
endmodule

// File: rtl/tdma_tx_reader.sv
`timescale 1ns/1ps
module tdma_tx_reader
  import tdma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 11,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              sf_mode,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_first,
  output logic              tx_last,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_desc
);
  localparam int FREE_W = $clog2(FIFO_DEPTH+1);
  localparam int BEAT_W = $bits(tx_beat_t);

  logic              push, pop, fifo_empty;
  tx_beat_t          push_beat, pop_beat;
  logic [FREE_W-1:0] fifo_free;
  logic [BEAT_W-1:0] pop_raw;

  tdma_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .FREE_W(FREE_W)) walker_i (
    .clk(clk), .rst_n(rst_n), .kick(kick), .base_wr(base_wr), .base_addr(base_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .fifo_free(fifo_free),
    .push(push), .push_beat(push_beat), .busy(busy), .cur_desc(cur_desc)
  );

  tdma_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(BEAT_W)) fifo_i (
    .clk(clk), .rst_n(rst_n), .wr_en(push), .wr_data(push_beat),
    .rd_en(pop), .rd_data(pop_raw), .empty(fifo_empty), .free(fifo_free)
  );

  assign pop_beat = tx_beat_t'(pop_raw);

  tdma_sf_gate #(.DEPTH(FIFO_DEPTH)) gate_i (
    .clk(clk), .rst_n(rst_n), .sf_mode(sf_mode),
    .push(push), .push_last(push_beat.last),
    .pop(pop), .pop_last(pop_beat.last),
    .empty(fifo_empty), .avail(tx_valid)
  );

  assign pop      = tx_valid && tx_ready;
  assign tx_data  = pop_beat.data;
  assign tx_first = pop_beat.first;
  assign tx_last  = pop_beat.last;

  assert_hold_tx_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_first) && $stable(tx_last)));
endmodule

// File: tb/tdma_tx_reader_tb.sv
`timescale 1ns/1ps
module tdma_tx_reader_tb_top;
  logic        clk, rst_n, kick, base_wr, sf_mode;
  logic [31:0] base_addr;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_ready, tx_first, tx_last, busy;
  logic [7:0]  tx_data;
  logic [31:0] cur_desc;

  tdma_tx_reader dut_i (
    .clk(clk), .rst_n(rst_n), .kick(kick), .base_wr(base_wr), .base_addr(base_addr),
    .sf_mode(sf_mode), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_first(tx_first), .tx_last(tx_last), .busy(busy), .cur_desc(cur_desc)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] mem [0:255];
  logic [64:0] exp_acc [$];
  logic [9:0]  exp_byte [$];
  logic        hw_en;
  logic [31:0] hw_addr, hw_data;
  logic        bp, sf_chk, ct_chk, lastword_seen, ct_early;
  logic [31:0] watch_addr, exp_final;
  int          ck_c, er_c, ck_i, er_i, cyc, wait_cnt, dly_seq;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (hw_en) mem[hw_addr[9:2]] = hw_data;
    mem_ack = 1'b0;
    if (rst_n && mem_req) begin
      if (wait_cnt == 0) begin
        mem_ack   = 1'b1;
        mem_rdata = mem[mem_addr[9:2]];
        ck_c = ck_c + 1;
        if (exp_acc.size() == 0) begin
          er_c = er_c + 1;
          $display("FAIL R2/R4: unexpected access we=%0b addr=%h, expected none", mem_we, mem_addr);
        end else begin
          logic [64:0] e;
          e = exp_acc.pop_front();
          if (e[64] != mem_we || e[63:32] != mem_addr || (mem_we && e[31:0] != mem_wdata)) begin
            er_c = er_c + 1;
            $display("FAIL R3/R5/R7/R8: access we=%0b addr=%h wdata=%h, expected we=%0b addr=%h wdata=%h",
                     mem_we, mem_addr, mem_wdata, e[64], e[63:32], e[31:0]);
          end
        end
        if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
        else if (mem_addr == watch_addr) lastword_seen = 1'b1;
        wait_cnt = dly_seq % 3;
        dly_seq  = dly_seq + 1;
      end else begin
        wait_cnt = wait_cnt - 1;
      end
    end
    tx_ready = !(bp && (cyc % 3 == 0));
    if (rst_n && tx_valid) begin
      if (sf_chk && !lastword_seen) begin
        ck_c = ck_c + 1; er_c = er_c + 1;
        $display("FAIL R10: byte offered before last word read, actual tx_valid=1 expected 0");
      end
      if (ct_chk && !lastword_seen) ct_early = 1'b1;
      if (tx_ready) begin
        ck_c = ck_c + 1;
        if (exp_byte.size() == 0) begin
          er_c = er_c + 1;
          $display("FAIL R5: unexpected byte %h, expected none", tx_data);
        end else begin
          logic [9:0] b;
          b = exp_byte.pop_front();
          if (b != {tx_last, tx_first, tx_data}) begin
            er_c = er_c + 1;
            $display("FAIL R5/R6: byte last/first/data=%b/%b/%h, expected %b/%b/%h",
                     tx_last, tx_first, tx_data, b[9], b[8], b[7:0]);
          end
        end
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    ck_i = ck_i + 1;
    if (!ok) begin
      er_i = er_i + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic host_wr(input logic [31:0] a, input logic [31:0] d);
    hw_addr = a; hw_data = d; hw_en = 1'b1;
    @(negedge clk); #1;
    hw_en = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] st, input logic [31:0] ctl,
                          input logic [31:0] bufa, input logic [31:0] nxt);
    host_wr(a, st); host_wr(a + 4, ctl); host_wr(a + 8, bufa); host_wr(a + 12, nxt);
  endtask

  // Behavioural walk over a copy of memory: predicts accesses, bytes and stop address
  task automatic build_expect(input logic [31:0] start);
    logic [31:0] sh [0:255];
    logic [31:0] a, st, ctl, bufa, nxt;
    int len;
    for (int i = 0; i < 256; i++) sh[i] = mem[i];
    a = start;
    for (int guard = 0; guard < 64; guard++) begin
      st = sh[a[9:2]];
      exp_acc.push_back({1'b0, a, 32'h0});
      if (!st[31]) break;
      ctl  = sh[(a + 4) >> 2];
      bufa = sh[(a + 8) >> 2];
      nxt  = sh[(a + 12) >> 2];
      exp_acc.push_back({1'b0, a + 32'd4, 32'h0});
      exp_acc.push_back({1'b0, a + 32'd8, 32'h0});
      exp_acc.push_back({1'b0, a + 32'd12, 32'h0});
      len = int'(ctl[10:0]);
      for (int w = 0; w < (len + 3) / 4; w++) exp_acc.push_back({1'b0, bufa + 32'(4 * w), 32'h0});
      for (int i = 0; i < len; i++) begin
        logic [31:0] wv;
        wv = sh[(bufa + 32'(i)) >> 2];
        exp_byte.push_back({ctl[30] && (i == len - 1), ctl[29] && (i == 0), wv[8 * (i % 4) +: 8]});
      end
      exp_acc.push_back({1'b1, a, st & 32'h7FFF_FFFF});
      sh[a[9:2]] = st & 32'h7FFF_FFFF;
      a = ctl[24] ? nxt : a + 32'd16;
    end
    exp_final = a;
  endtask

  task automatic pulse_base(input logic [31:0] a);
    base_addr = a; base_wr = 1'b1;
    @(negedge clk); #1;
    base_wr = 1'b0;
  endtask

  task automatic run_walk(input string tag);
    int t;
    kick = 1'b1;
    @(negedge clk); #1;
    kick = 1'b0;
    t = 0;
    while ((busy || exp_byte.size() != 0 || exp_acc.size() != 0 || tx_valid) && t < 20000) begin
      @(negedge clk); #1;
      t++;
    end
    chk(t < 20000, {tag, " walk completes"}, t, 0);
    chk(!busy, {tag, " idle after walk"}, busy, 0);
    chk(cur_desc == exp_final, {tag, " stop address"}, cur_desc, exp_final);
  endtask

  localparam logic [31:0] F_LAST = 32'h4000_0000, F_FIRST = 32'h2000_0000, F_CHAIN = 32'h0100_0000;

  initial begin
    ck_c = 0; er_c = 0; ck_i = 0; er_i = 0; cyc = 0; wait_cnt = 0; dly_seq = 1;
    rst_n = 1'b0; kick = 1'b0; base_wr = 1'b0; base_addr = '0; sf_mode = 1'b0;
    hw_en = 1'b0; hw_addr = '0; hw_data = '0; mem_ack = 1'b0; mem_rdata = '0; tx_ready = 1'b1;
    bp = 1'b0; sf_chk = 1'b0; ct_chk = 1'b0; lastword_seen = 1'b0; ct_early = 1'b0;
    watch_addr = 32'hFFFF_FFFF; exp_final = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(mem_req == 1'b0, "R1 mem_req", mem_req, 0);
    chk(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
    chk(cur_desc == 32'h0, "R1 cur_desc", cur_desc, 0);

    for (int w = 0; w < 256; w++) host_wr(32'(w * 4), (w < 64) ? (32'h9E37_79B9 * 32'(w + 1)) : 32'h0);

    // Chained ring of three, wrap back to the first, with transmit backpressure (R2 R4 R7 R8 R12)
    put_desc(32'h100, 32'h8000_00A5, F_FIRST | F_LAST | F_CHAIN | 32'd5, 32'h000, 32'h140);
    put_desc(32'h140, 32'h8000_0000, F_FIRST | F_CHAIN | 32'd8, 32'h020, 32'h180);
    put_desc(32'h180, 32'h8000_1234, F_LAST | F_CHAIN | 32'd3, 32'h040, 32'h100);
    bp = 1'b1;
    pulse_base(32'h100);
    chk(cur_desc == 32'h100, "R2 base load", cur_desc, 32'h100);
    build_expect(32'h100);
    run_walk("R4 R8 ring");
    chk(mem[32'h100 >> 2] == 32'h0000_00A5, "R7 status writeback", mem[32'h100 >> 2], 32'h0000_00A5);
    chk(mem[32'h180 >> 2] == 32'h0000_1234, "R7 status writeback", mem[32'h180 >> 2], 32'h0000_1234);

    // Sequential descriptors, zero length first (R8 R9)
    bp = 1'b0;
    put_desc(32'h200, 32'h8000_0001, F_FIRST | F_LAST, 32'h060, 32'hDEAD_0000);
    put_desc(32'h210, 32'h8000_0002, F_FIRST | F_LAST | 32'd6, 32'h060, 32'h100);
    put_desc(32'h220, 32'h0000_0000, 32'h0, 32'h0, 32'h0);
    pulse_base(32'h200);
    build_expect(32'h200);
    run_walk("R8 R9 sequential");
    chk(mem[32'h200 >> 2] == 32'h0000_0001, "R9 zero-length writeback", mem[32'h200 >> 2], 32'h1);

    // Store-and-forward frame of 13 bytes (R10), then resume without reload (R2)
    sf_mode = 1'b1;
    put_desc(32'h300, 32'h8000_0000, F_FIRST | F_LAST | F_CHAIN | 32'd13, 32'h080, 32'h340);
    put_desc(32'h340, 32'h0000_0000, 32'h0, 32'h0, 32'h0);
    pulse_base(32'h300);
    watch_addr = 32'h08C; lastword_seen = 1'b0; sf_chk = 1'b1;
    build_expect(32'h300);
    run_walk("R10 store-forward");
    sf_chk = 1'b0;
    put_desc(32'h340, 32'h8000_0003, F_FIRST | F_LAST | F_CHAIN | 32'd4, 32'h0A0, 32'h300);
    build_expect(32'h340);
    run_walk("R2 resume");

    // Cut-through frame of 13 bytes (R10)
    sf_mode = 1'b0;
    put_desc(32'h380, 32'h8000_0000, F_FIRST | F_LAST | F_CHAIN | 32'd13, 32'h0C0, 32'h3C0);
    put_desc(32'h3C0, 32'h0000_0000, 32'h0, 32'h0, 32'h0);
    pulse_base(32'h380);
    watch_addr = 32'h0CC; lastword_seen = 1'b0; ct_early = 1'b0; ct_chk = 1'b1;
    build_expect(32'h380);
    run_walk("R10 cut-through");
    ct_chk = 1'b0;
    chk(ct_early == 1'b1, "R10 cut-through early byte", ct_early, 1);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", ck_c + ck_i, er_c + er_i);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: run did not end, actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", ck_c + ck_i + 1, er_c + er_i + 1);
    $finish;
  end
endmodule